// File: doc/BRIEF.md
# Addressed Three-Wire Serial Settings Receiver

This block accepts control words from a three-wire serial bus made of a bit clock, a data line and an active-low frame enable. All three wires are brought into the system clock domain through two-flop synchronisers. Edges are detected on the synchronised copies. A frame opens when the enable falls. The first two data bits form a device address. When that address matches, the block shifts in any number of further bits and keeps only the most recent nine. When the enable rises, those nine bits are split into a three-bit function index and a six-bit value. The value is written into one of eight function registers, but only if the address matched and at least nine bits followed it.

The receive side is built around a four-state machine. The states are `ST_IDLE` (no frame open), `ST_ADDR` (collecting address bits), `ST_DATA` (address accepted, shifting payload) and `ST_SKIP` (address rejected, frame ignored). The transitions are:

- any state goes to `ST_ADDR` on an enable fall;
- `ST_ADDR` goes to `ST_DATA` or `ST_SKIP` on the second address bit, according to the match;
- `ST_ADDR`, `ST_DATA` and `ST_SKIP` return to `ST_IDLE` on an enable rise, and the commit is raised on that same transition out of `ST_DATA` when the payload is full.

A register bank holds the eight settings. It pulses an update strobe, with the index written, for one system clock each time it writes.

Top module: `serial_ctl_rx`

## Requirements
- R1: After reset, every function setting reads zero, the update strobe is low and the update index is zero.
- R2: A frame starts when `ser_en_n_i` falls, and the first two bits sampled in it are the address. Only the address sequence 1 then 0 (first bit 1) is accepted.
- R3: A frame whose address is anything other than 1 then 0 changes no setting and produces no strobe.
- R4: After an accepted address any number of bits may follow. Only the last nine received before the enable rises are used.
- R5: Of those nine bits, the first three received form the function index, most significant bit first. The last six form the value, most significant bit first. Function i appears on `settings_o[i*6 +: 6]`.
- R6: Settings change only after the enable rises. Shifting bits while the enable is low alters no output.
- R7: If fewer than nine bits follow an accepted address, the frame is discarded and no setting or strobe changes.
- R8: Activity on the data and clock wires while the enable is high is ignored.
- R9: Each write raises `upd_stb_o` for exactly one system clock, with `upd_idx_o` holding the function written. The new value is visible in that same cycle.
- R10: Data is sampled only on rising edges of `ser_clk_i`. Changes of `ser_dat_i` while the serial clock is high have no effect.
- R11: An enable fall clears the address state of the previous frame, so a matched address in one frame never enables a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_dat_i | input | 1 | Serial data |
| ser_en_n_i | input | 1 | Active-low frame enable |
| settings_o | output | 48 | Eight six-bit settings, function i at bits i*6+5..i*6 |
| upd_stb_o | output | 1 | One-cycle pulse on each setting write |
| upd_idx_o | output | 3 | Index of the function most recently written |

## Verification
The bench runs a behavioural model that follows the synchronised serial wires with queues and compares every output on every clock. On top of that, it goes after these corners:

- Long frames with leading junk. A design that kept the first nine bits would write the wrong function.
- Frames with eight payload bits. A design that committed short frames would corrupt a setting.
- Rejected addresses 01, 11 and 00, including one that follows a short frame with a good address. A design that kept the old match would write.
- Data flips while the serial clock is high. A design sampling on both edges would store inverted bits.
- A check between the last shifted bit and the enable release. A design updating early would show the value before release.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    // Frame-level states of the receiver
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // enable high, no frame open
        ST_ADDR = 2'd1,   // collecting device address bits
        ST_DATA = 2'd2,   // address accepted, shifting payload
        ST_SKIP = 2'd3    // address rejected, wait for enable release
    } frame_st_e;

endpackage

// File: rtl/sctl_sync.sv
// Multi-bit synchroniser: each wire gets its own flop chain plus one extra
// stage holding the previous synchronised value for edge detection.
module sctl_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_prev_o
);

    localparam int CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < W; g++) begin : g_wire
        logic [CHAIN_W-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {CHAIN_W{RST_VAL[g]}};
            end else begin
                chain_q <= {chain_q[CHAIN_W-2:0], d_i[g]};
            end
        end

        assign q_o[g]      = chain_q[STAGES-1];
        assign q_prev_o[g] = chain_q[STAGES];
    end

endmodule

// File: rtl/sctl_frame.sv
// Frame state machine: address check, payload shift register, commit decision.
module sctl_frame
    import sctl_pkg::*;
#(
    parameter int                ADDR_W   = 2,
    parameter logic [ADDR_W-1:0] ADDR_VAL = 2'b10,
    parameter int                WORD_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sclk_prev_i,
    input  logic              sdat_i,
    input  logic              sen_n_i,
    input  logic              sen_n_prev_i,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);

    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int ACNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
    localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(WORD_W);
    localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_W - 1);

    frame_st_e           state_q, state_d;
    logic [ADDR_W-1:0]   addr_sh_q;
    logic [ACNT_W-1:0]   addr_cnt_q;
    logic [WORD_W-1:0]   word_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                commit_q;

    logic                en_fall, en_rise, bit_stb;
    logic [ADDR_W-1:0]   addr_next;
    logic                addr_last, addr_ok, word_full;

    // Edge qualification on synchronised wires
    assign en_fall   = sen_n_prev_i & ~sen_n_i;
    assign en_rise   = ~sen_n_prev_i & sen_n_i;
    assign bit_stb   = ~sen_n_i & sclk_i & ~sclk_prev_i;
    assign addr_next = {addr_sh_q[ADDR_W-2:0], sdat_i};
    assign addr_last = (addr_cnt_q == ACNT_LAST);
    assign addr_ok   = (addr_next == ADDR_VAL);
    assign word_full = (cnt_q == CNT_FULL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_fall) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (en_fall) begin
                    state_d = ST_ADDR;
                end else if (en_rise) begin
                    state_d = ST_IDLE;
                end else if (bit_stb && addr_last) begin
                    state_d = addr_ok ? ST_DATA : ST_SKIP;
                end
            end
            ST_DATA: begin
                if (en_fall) begin
                    state_d = ST_ADDR;
                end else if (en_rise) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SKIP: begin
                if (en_fall) begin
                    state_d = ST_ADDR;
                end else if (en_rise) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sh_q  <= '0;
            addr_cnt_q <= '0;
            word_q     <= '0;
            cnt_q      <= '0;
            commit_q   <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (en_fall) begin
                addr_sh_q  <= '0;
                addr_cnt_q <= '0;
                cnt_q      <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR: begin
                        if (bit_stb) begin
                            addr_sh_q  <= addr_next;
                            addr_cnt_q <= addr_cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (bit_stb) begin
                            word_q <= {word_q[WORD_W-2:0], sdat_i};
                            if (!word_full) begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        if (en_rise && word_full) begin
                            commit_q <= 1'b1;
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign word_o   = word_q;
    assign commit_o = commit_q;

    // R7
    commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> $past(cnt_q) == CNT_FULL);

    // R3
    commit_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> $past(state_q) == ST_DATA);

    // R8
    word_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_n_i && sen_n_prev_i) |=> $stable(word_q));

    // R6
    commit_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> $past(en_rise));

endmodule

// File: rtl/sctl_bank.sv
// Function register bank with update strobe.
module sctl_bank #(
    parameter int SEL_W = 3,
    parameter int VAL_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [SEL_W+VAL_W-1:0]        word_i,
    output logic [(1<<SEL_W)*VAL_W-1:0]   settings_o,
    output logic                          upd_stb_o,
    output logic [SEL_W-1:0]              upd_idx_o
);

    localparam int NFUNC = 1 << SEL_W;

    logic [SEL_W-1:0] sel;
    logic [VAL_W-1:0] val;
    logic             stb_q;
    logic [SEL_W-1:0] idx_q;

    assign sel = word_i[SEL_W+VAL_W-1:VAL_W];
    assign val = word_i[VAL_W-1:0];

    for (genvar g = 0; g < NFUNC; g++) begin : g_func
        logic [VAL_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_i && (sel == SEL_W'(g))) begin
                val_q <= val;
            end
        end

        assign settings_o[g*VAL_W +: VAL_W] = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            idx_q <= '0;
        end else begin
            stb_q <= wr_i;
            if (wr_i) begin
                idx_q <= sel;
            end
        end
    end

    assign upd_stb_o = stb_q;
    assign upd_idx_o = idx_q;

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);

    // R6
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(settings_o));

    // R9
    stb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> settings_o[int'(idx_q)*VAL_W +: VAL_W] == $past(val));

endmodule

// File: rtl/serial_ctl_rx.sv
// Top: addressed three-wire serial settings receiver.
module serial_ctl_rx #(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 2,
    parameter logic [1:0]  ADDR_VAL    = 2'b10,
    parameter int          SEL_W       = 3,
    parameter int          VAL_W       = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ser_clk_i,
    input  logic                         ser_dat_i,
    input  logic                         ser_en_n_i,
    output logic [(1<<SEL_W)*VAL_W-1:0]  settings_o,
    output logic                         upd_stb_o,
    output logic [SEL_W-1:0]             upd_idx_o
);

    localparam int WORD_W = SEL_W + VAL_W;
    // wire order in the synchroniser: {enable, data, clock}
    localparam logic [2:0] IDLE_PINS = 3'b100;

    logic [2:0]        pins_cur, pins_prev;
    logic [WORD_W-1:0] word;
    logic              commit;

    sctl_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_i      ({ser_en_n_i, ser_dat_i, ser_clk_i}),
        .q_o      (pins_cur),
        .q_prev_o (pins_prev)
    );

    sctl_frame #(
        .ADDR_W   (ADDR_W),
        .ADDR_VAL (ADDR_VAL[ADDR_W-1:0]),
        .WORD_W   (WORD_W)
    ) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (pins_cur[0]),
        .sclk_prev_i  (pins_prev[0]),
        .sdat_i       (pins_cur[1]),
        .sen_n_i      (pins_cur[2]),
        .sen_n_prev_i (pins_prev[2]),
        .word_o       (word),
        .commit_o     (commit)
    );

    sctl_bank #(
        .SEL_W (SEL_W),
        .VAL_W (VAL_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (commit),
        .word_i     (word),
        .settings_o (settings_o),
        .upd_stb_o  (upd_stb_o),
        .upd_idx_o  (upd_idx_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !upd_stb_o);

endmodule

// File: tb/tb_serial_ctl_rx.sv
module tb_serial_ctl_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en_n = 1'b1;
    logic [47:0] settings;
    logic        upd_stb;
    logic [2:0]  upd_idx;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    serial_ctl_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_dat_i  (ser_dat),
        .ser_en_n_i (ser_en_n),
        .settings_o (settings),
        .upd_stb_o  (upd_stb),
        .upd_idx_o  (upd_idx)
    );

    // ---------------- behavioural reference model ----------------
    int hist_en[$];
    int hist_dat[$];
    int hist_clk[$];
    int abits[$];
    int dbits[$];
    int mode = 0;            // 0 idle, 1 address, 2 payload, 3 rejected
    int exp_set[8];
    int exp_stb = 0;
    int exp_idx = 0;
    bit pend = 1'b0;
    int pend_sel = 0;
    int pend_val = 0;

    task automatic model_reset();
        hist_en.delete(); hist_dat.delete(); hist_clk.delete();
        for (int i = 0; i < 4; i++) begin
            hist_en.push_front(1); hist_dat.push_front(0); hist_clk.push_front(0);
        end
        abits.delete(); dbits.delete();
        mode = 0; pend = 1'b0; exp_stb = 0; exp_idx = 0;
        for (int i = 0; i < 8; i++) exp_set[i] = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int ce, pe, cc, pc, cd;
            exp_stb = 0;
            if (pend) begin
                exp_set[pend_sel] = pend_val;
                exp_idx = pend_sel;
                exp_stb = 1;
                pend = 1'b0;
            end
            hist_en.push_front(int'(ser_en_n));
            hist_dat.push_front(int'(ser_dat));
            hist_clk.push_front(int'(ser_clk));
            ce = hist_en[2]; pe = hist_en[3];
            cc = hist_clk[2]; pc = hist_clk[3];
            cd = hist_dat[2];
            void'(hist_en.pop_back()); void'(hist_dat.pop_back()); void'(hist_clk.pop_back());
            if (pe == 1 && ce == 0) begin
                mode = 1; abits.delete(); dbits.delete();
            end else if (pe == 0 && ce == 1) begin
                if (mode == 2 && dbits.size() == 9) begin
                    pend = 1'b1;
                    pend_sel = dbits[0]*4 + dbits[1]*2 + dbits[2];
                    pend_val = 0;
                    for (int k = 3; k < 9; k++) pend_val = pend_val*2 + dbits[k];
                end
                mode = 0;
            end else if (ce == 0 && pc == 0 && cc == 1) begin
                if (mode == 1) begin
                    abits.push_back(cd);
                    if (abits.size() == 2)
                        mode = (abits[0] == 1 && abits[1] == 0) ? 2 : 3;
                end else if (mode == 2) begin
                    dbits.push_back(cd);
                    if (dbits.size() > 9) void'(dbits.pop_front());
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (upd_stb !== exp_stb[0] || upd_idx !== 3'(exp_idx)) begin
                errors++;
                $display("FAIL R9 model: stb/idx actual %0b/%0d expected %0d/%0d",
                         upd_stb, upd_idx, exp_stb, exp_idx);
            end
            for (int i = 0; i < 8; i++) begin
                if (settings[i*6 +: 6] !== 6'(exp_set[i])) begin
                    errors++;
                    $display("FAIL R6 model: f%0d actual %0h expected %0h",
                             i, settings[i*6 +: 6], exp_set[i]);
                end
            end
        end
    end

    always @(posedge clk) if (rst_n && upd_stb) stb_cnt++;

    // ---------------- helpers ----------------
    task automatic check_val(input string req, input int idx, input int expv);
        checks++;
        if (settings[idx*6 +: 6] !== 6'(expv)) begin
            errors++;
            $display("FAIL %s: f%0d actual %0h expected %0h", req, idx, settings[idx*6 +: 6], expv);
        end
    endtask

    task automatic check_int(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic ser_half();
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_begin();
        ser_en_n = 1'b0;
        ser_half();
    endtask

    task automatic shift_bits(input logic [63:0] v, input int n, input bit glitch);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            ser_half();
            ser_clk = 1'b1;
            if (glitch) begin
                repeat (2) @(negedge clk);
                ser_dat = ~v[i];
                repeat (2) @(negedge clk);
            end else begin
                ser_half();
            end
            ser_clk = 1'b0;
        end
    endtask

    task automatic frame_end();
        ser_half();
        ser_en_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int n);
        frame_begin();
        shift_bits(v, n, 1'b0);
        frame_end();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 8; i++) check_val("R1", i, 0);
        check_int("R1 stb", int'(upd_stb), 0);
        check_int("R1 idx", int'(upd_idx), 0);

        // R2 / R5: address 10, function 3, value 0x2A
        send({53'd0, 2'b10, 3'd3, 6'h2A}, 11);
        check_val("R2", 3, 'h2A);
        check_val("R5", 0, 0);
        check_int("R9 count", stb_cnt, 1);
        check_int("R9 idx", int'(upd_idx), 3);

        // R4: seven junk bits ahead of the final nine
        send({46'd0, 2'b10, 7'b1011001, 3'd5, 6'h15}, 18);
        check_val("R4", 5, 'h15);
        check_val("R4", 3, 'h2A);

        // R3: rejected addresses
        send({53'd0, 2'b01, 3'd3, 6'h3F}, 11);
        send({53'd0, 2'b11, 3'd3, 6'h3F}, 11);
        send({53'd0, 2'b00, 3'd3, 6'h3F}, 11);
        check_val("R3", 3, 'h2A);
        check_int("R3 count", stb_cnt, 2);

        // R7: short payloads
        send({54'd0, 2'b10, 8'hFF}, 10);
        send({62'd0, 2'b10}, 2);
        check_int("R7 count", stb_cnt, 2);
        check_val("R7", 7, 0);

        // R6: nothing changes before release
        frame_begin();
        shift_bits({53'd0, 2'b10, 3'd1, 6'h33}, 11, 1'b0);
        repeat (12) @(negedge clk);
        check_val("R6 pre", 1, 0);
        check_int("R6 pre count", stb_cnt, 2);
        frame_end();
        check_val("R6 post", 1, 'h33);

        // R8: wire activity with enable high
        for (int i = 0; i < 6; i++) begin
            ser_dat = i[0];
            ser_half();
            ser_clk = 1'b1;
            ser_half();
            ser_clk = 1'b0;
        end
        repeat (12) @(negedge clk);
        check_int("R8 count", stb_cnt, 3);
        check_val("R8", 1, 'h33);

        // R10: data flips while serial clock is high
        frame_begin();
        shift_bits({53'd0, 2'b10, 3'd6, 6'h2D}, 11, 1'b1);
        frame_end();
        check_val("R10", 6, 'h2D);

        // R11: good address in short frame, then rejected address frame
        send({57'd0, 2'b10, 5'b10101}, 7);
        send({53'd0, 2'b11, 3'd3, 6'h01}, 11);
        check_val("R11", 3, 'h2A);

        // R5: top function, full value; overwrite with zero
        send({53'd0, 2'b10, 3'd7, 6'h3F}, 11);
        check_val("R5 top", 7, 'h3F);
        check_int("R5 idx", int'(upd_idx), 7);
        send({53'd0, 2'b10, 3'd3, 6'h00}, 11);
        check_val("R5 zero", 3, 0);

        // R1: reset mid-run clears settings
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) check_val("R1 rerun", i, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule